// File: doc/BRIEF.md
# Dual-Port Mailbox Interrupt Generator

This block raises a doorbell interrupt between the two sides of a dual-port memory. Each side owns one mailbox word at the top of the address space. The left side's mailbox is the second-highest address (0x3FFFE for 18-bit addresses) and the right side's mailbox is the highest address (0x3FFFF). When one side writes the other side's mailbox, the other side's active-low interrupt line falls. When the owning side reads its mailbox back, its own line rises again. The mailbox contents stay ordinary words in the memory array, which lies outside this block.

The block watches each port's enable, output enable, write strobe (all active low), address and busy status. Every update is registered on the clock edge that follows the qualifying access. A port whose busy input is low cannot change any flag. A function-enable input lets the two top addresses serve as plain storage. While that input is low, both interrupt lines are held inactive.

Top module: `mbx_irq_top`

## Requirements
- R1: A synchronous active-high reset drives both `l_irq_n` and `r_irq_n` high on the clock edge where it is sampled.
- R2: A right-port write (`r_en_n`=0 and `r_wr_n`=0) to address 0x3FFFE drives `l_irq_n` low on the next clock edge.
- R3: A left-port access with `l_en_n`=0 and `l_oe_n`=0 at 0x3FFFE drives `l_irq_n` high on the next edge, whatever the level of `l_wr_n`.
- R4: A left-port write (`l_en_n`=0 and `l_wr_n`=0) to address 0x3FFFF drives `r_irq_n` low on the next clock edge.
- R5: A right-port access with `r_en_n`=0 and `r_oe_n`=0 at 0x3FFFF drives `r_irq_n` high on the next edge, whatever the level of `r_wr_n`.
- R6: When the acting port's busy input is low (0 = busy), its set access or clear access leaves the affected interrupt line unchanged.
- R7: When the same flag sees a set and a clear in one cycle, the set wins and the line goes low.
- R8: While `irq_func_en` is 0, both interrupt lines are high on every edge, and no access to 0x3FFFE or 0x3FFFF sets a flag.
- R9: Accesses that do not qualify leave both lines unchanged. These are: writes to any other address, accesses with the port enable high, a port writing its own mailbox while its output enable is high, and an opposite-port read of a mailbox.
- R10: With no qualifying access, each interrupt line holds its value from one cycle to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| irq_func_en | input | 1 | 1 = mailbox interrupts on; 0 = both flags cleared and held |
| l_en_n | input | 1 | Left port enable, active low |
| l_oe_n | input | 1 | Left port output enable, active low |
| l_wr_n | input | 1 | Left port write strobe, 0 = write |
| l_addr | input | 18 | Left port address |
| l_busy_n | input | 1 | Left port busy status, 0 = busy (updates suppressed) |
| r_en_n | input | 1 | Right port enable, active low |
| r_oe_n | input | 1 | Right port output enable, active low |
| r_wr_n | input | 1 | Right port write strobe, 0 = write |
| r_addr | input | 18 | Right port address |
| r_busy_n | input | 1 | Right port busy status, 0 = busy |
| l_irq_n | output | 1 | Left port interrupt, active low |
| r_irq_n | output | 1 | Right port interrupt, active low |

## Verification
The assertions assume that all control and address inputs are synchronous to `clk` and settle before each rising edge. They also assume that `irq_func_en` only changes between accesses, and that each access is seen for exactly one sampled cycle. The stimulus changes every input on the falling edge and holds it for one full period. Idle cycles keep both enables high. Same-cycle set/clear collisions and both-busy cycles are built on purpose, so that the priority and suppression checks each see their triggering case.

// File: rtl/mbx_irq_pkg.sv
package mbx_irq_pkg;

    parameter int MBX_ADDR_W = 18;

    localparam logic [MBX_ADDR_W-1:0] LEFT_BOX  = {{(MBX_ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [MBX_ADDR_W-1:0] RIGHT_BOX = {MBX_ADDR_W{1'b1}};

    typedef enum logic {SIDE_LEFT = 1'b0, SIDE_RIGHT = 1'b1} side_e;

    typedef struct packed {
        logic                  en_n;
        logic                  oe_n;
        logic                  wr_n;
        logic [MBX_ADDR_W-1:0] addr;
        logic                  busy_n;
    } port_bus_t;

    typedef struct packed {
        logic set_other;
        logic clr_own;
    } port_evt_t;

    function automatic logic is_write(input port_bus_t p);
        return !p.en_n && !p.wr_n;
    endfunction

    function automatic logic is_fetch(input port_bus_t p);
        return !p.en_n && !p.oe_n;
    endfunction

    function automatic logic [MBX_ADDR_W-1:0] own_box(input side_e s);
        return (s == SIDE_LEFT) ? LEFT_BOX : RIGHT_BOX;
    endfunction

    function automatic logic [MBX_ADDR_W-1:0] peer_box(input side_e s);
        return (s == SIDE_LEFT) ? RIGHT_BOX : LEFT_BOX;
    endfunction

endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
    import mbx_irq_pkg::*;
#(
    parameter side_e SIDE = SIDE_LEFT
) (
    input  logic      func_en,
    input  port_bus_t bus,
    output port_evt_t evt
);
    localparam logic [MBX_ADDR_W-1:0] OWN_A  = own_box(SIDE);
    localparam logic [MBX_ADDR_W-1:0] PEER_A = peer_box(SIDE);

    logic allowed;

    always_comb begin
        allowed       = func_en && bus.busy_n;
        evt.set_other = allowed && is_write(bus) && (bus.addr == PEER_A);
        evt.clr_own   = allowed && is_fetch(bus) && (bus.addr == OWN_A);
    end
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
    input  logic clk,
    input  logic rst,
    input  logic func_en,
    input  logic set_req,
    input  logic clr_req,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst || !func_en) begin
            flag <= 1'b0;
        end else if (set_req) begin
            flag <= 1'b1;
        end else if (clr_req) begin
            flag <= 1'b0;
        end
    end

    // R7
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        (func_en && set_req) |=> flag);

    // R3
    clear_takes_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_req && !set_req) |=> !flag);

    // R10
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        (func_en && !set_req && !clr_req) |=> $stable(flag));
endmodule

// File: rtl/mbx_irq_top.sv
module mbx_irq_top
    import mbx_irq_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  irq_func_en,
    input  logic                  l_en_n,
    input  logic                  l_oe_n,
    input  logic                  l_wr_n,
    input  logic [MBX_ADDR_W-1:0] l_addr,
    input  logic                  l_busy_n,
    input  logic                  r_en_n,
    input  logic                  r_oe_n,
    input  logic                  r_wr_n,
    input  logic [MBX_ADDR_W-1:0] r_addr,
    input  logic                  r_busy_n,
    output logic                  l_irq_n,
    output logic                  r_irq_n
);
    localparam int NPORT = 2;

    port_bus_t bus   [NPORT];
    port_evt_t evt   [NPORT];
    logic      flag  [NPORT];

    always_comb begin
        bus[0] = '{en_n: l_en_n, oe_n: l_oe_n, wr_n: l_wr_n, addr: l_addr, busy_n: l_busy_n};
        bus[1] = '{en_n: r_en_n, oe_n: r_oe_n, wr_n: r_wr_n, addr: r_addr, busy_n: r_busy_n};
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_port
        localparam side_e SD = (p == 0) ? SIDE_LEFT : SIDE_RIGHT;

        mbx_port_decode #(.SIDE(SD)) i_dec (
            .func_en (irq_func_en),
            .bus     (bus[p]),
            .evt     (evt[p])
        );

        mbx_flag i_flag (
            .clk     (clk),
            .rst     (rst),
            .func_en (irq_func_en),
            .set_req (evt[NPORT-1-p].set_other),
            .clr_req (evt[p].clr_own),
            .flag    (flag[p])
        );
    end

    assign l_irq_n = ~flag[0];
    assign r_irq_n = ~flag[1];

    // R8
    func_off_chk: assert property (@(posedge clk) disable iff (rst)
        !irq_func_en |=> (l_irq_n && r_irq_n));

    // R6
    both_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_func_en && !l_busy_n && !r_busy_n) |=> ($stable(l_irq_n) && $stable(r_irq_n)));

    // R2
    left_set_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_func_en && r_busy_n && !r_en_n && !r_wr_n && r_addr == LEFT_BOX) |=> !l_irq_n);

    // R4
    right_set_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_func_en && l_busy_n && !l_en_n && !l_wr_n && l_addr == RIGHT_BOX) |=> !r_irq_n);
endmodule

// File: tb/test_mbx_irq_top.sv
module test_mbx_irq_top;
    import mbx_irq_pkg::*;

    typedef struct {
        logic  l_n;
        logic  r_n;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic fen = 1'b1;
    logic l_en_n = 1'b1, l_oe_n = 1'b1, l_wr_n = 1'b1, l_busy_n = 1'b1;
    logic r_en_n = 1'b1, r_oe_n = 1'b1, r_wr_n = 1'b1, r_busy_n = 1'b1;
    logic [MBX_ADDR_W-1:0] l_addr = '0, r_addr = '0;
    logic l_irq_n, r_irq_n;

    int   n_run  = 0;
    int   n_fail = 0;
    exp_t sb_q[$];
    logic m_l = 1'b0, m_r = 1'b0;
    bit   finished = 1'b0;

    localparam logic [MBX_ADDR_W-1:0] LB = {{(MBX_ADDR_W-1){1'b1}}, 1'b0};
    localparam logic [MBX_ADDR_W-1:0] RB = {MBX_ADDR_W{1'b1}};

    always #5 clk = ~clk;

    mbx_irq_top i_mbx_irq_top (
        .clk(clk), .rst(rst), .irq_func_en(fen),
        .l_en_n(l_en_n), .l_oe_n(l_oe_n), .l_wr_n(l_wr_n), .l_addr(l_addr), .l_busy_n(l_busy_n),
        .r_en_n(r_en_n), .r_oe_n(r_oe_n), .r_wr_n(r_wr_n), .r_addr(r_addr), .r_busy_n(r_busy_n),
        .l_irq_n(l_irq_n), .r_irq_n(r_irq_n)
    );

    // monitor: compares each expected item just after the edge it belongs to
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (sb_q.size() > 0) begin
                exp_t e;
                e = sb_q.pop_front();
                n_run++;
                if (l_irq_n !== e.l_n || r_irq_n !== e.r_n) begin
                    n_fail++;
                    $display("FAIL %s: got l=%b r=%b expected l=%b r=%b",
                             e.tag, l_irq_n, r_irq_n, e.l_n, e.r_n);
                end
            end
        end
    end

    // driver: one access per cycle, model computed from the requirements
    task automatic step(input logic f,
                        input logic le, input logic lo, input logic lw,
                        input logic [MBX_ADDR_W-1:0] la, input logic lb,
                        input logic re, input logic ro, input logic rw,
                        input logic [MBX_ADDR_W-1:0] ra, input logic rb,
                        input string tag);
        exp_t e;
        logic ls, lc, rs, rc;
        @(negedge clk);
        rst = 1'b0; fen = f;
        l_en_n = le; l_oe_n = lo; l_wr_n = lw; l_addr = la; l_busy_n = lb;
        r_en_n = re; r_oe_n = ro; r_wr_n = rw; r_addr = ra; r_busy_n = rb;
        ls = f && rb && !re && !rw && ra == LB;
        lc = f && lb && !le && !lo && la == LB;
        rs = f && lb && !le && !lw && la == RB;
        rc = f && rb && !re && !ro && ra == RB;
        if (!f)      m_l = 1'b0;
        else if (ls) m_l = 1'b1;
        else if (lc) m_l = 1'b0;
        if (!f)      m_r = 1'b0;
        else if (rs) m_r = 1'b1;
        else if (rc) m_r = 1'b0;
        e.l_n = ~m_l; e.r_n = ~m_r; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic idle(input string tag);
        step(1'b1, 1,1,1, '0, 1, 1,1,1, '0, 1, tag);
    endtask

    initial begin
        exp_t e;
        // R1: reset state
        @(negedge clk);
        rst = 1'b1;
        e.l_n = 1'b1; e.r_n = 1'b1; e.tag = "R1 reset";
        sb_q.push_back(e);
        m_l = 1'b0; m_r = 1'b0;

        // R2: right writes left box
        step(1, 1,1,1, '0, 1,  0,1,0, LB, 1, "R2 set left");
        idle("R10 hold left");
        // R4: left writes right box
        step(1, 0,1,0, RB, 1,  1,1,1, '0, 1, "R4 set right");
        idle("R10 hold both");
        // R3: left fetch of own box with write strobe low clears
        step(1, 0,0,0, LB, 1,  1,1,1, '0, 1, "R3 clear left wr low");
        // R5: right fetch of own box
        step(1, 1,1,1, '0, 1,  0,0,1, RB, 1, "R5 clear right");
        // R9: non-qualifying accesses
        step(1, 0,1,0, 18'h3FFFD, 1, 0,1,0, 18'h00010, 1, "R9 other addr");
        step(1, 1,1,0, RB, 1,  1,1,0, LB, 1, "R9 enable high");
        step(1, 0,1,0, LB, 1,  0,1,0, RB, 1, "R9 own box write oe high");
        step(1, 0,0,1, RB, 1,  0,0,1, LB, 1, "R9 opposite read");
        // R6: busy suppresses set
        step(1, 0,1,0, RB, 0,  0,1,0, LB, 0, "R6 busy set");
        // set both then busy suppresses clear
        step(1, 0,1,0, RB, 1,  0,1,0, LB, 1, "R2 R4 set both");
        step(1, 0,0,1, LB, 0,  0,0,1, RB, 0, "R6 busy clear");
        step(1, 0,0,1, LB, 0,  0,0,1, RB, 1, "R6 left busy only");
        // R7: set vs clear collision on left flag
        step(1, 0,0,1, LB, 1,  0,1,0, LB, 1, "R7 set wins left");
        // R7 on right flag
        step(1, 0,1,0, RB, 1,  0,0,1, RB, 1, "R7 set wins right");
        idle("R10 hold");
        // R8: function off
        step(0, 1,1,1, '0, 1,  1,1,1, '0, 1, "R8 off clears");
        step(0, 0,1,0, RB, 1,  0,1,0, LB, 1, "R8 off no set");
        step(1, 1,1,1, '0, 1,  1,1,1, '0, 1, "R8 back on idle");
        step(1, 1,1,1, '0, 1,  0,1,0, LB, 1, "R2 set after enable");
        // R1: reset mid-run
        @(negedge clk);
        rst = 1'b1;
        r_en_n = 1'b1; l_en_n = 1'b1;
        m_l = 1'b0; m_r = 1'b0;
        e.l_n = 1'b1; e.r_n = 1'b1; e.tag = "R1 reset mid-run";
        sb_q.push_back(e);
        idle("R10 after reset");

        repeat (3) @(negedge clk);
        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule